// File: doc/BRIEF.md
# Event-to-CPU Interrupt Selector

This block sits between the latched event flags of a processor core and its twelve maskable interrupt request lines. The event space holds 128 entries. Numbers 4 to 127 are system events, and numbers 0 to 3 are the outputs of an event combiner. Each of the twelve request lines has its own 7-bit event selector and its own enable. The lines are numbered 4 to 15 on the CPU side. Any event can be routed to any line. A global enable gates all twelve maskable lines together. A separate enable gates the non-maskable request, which the global enable does not affect.

Software programs the block through a simple write port:
- Addresses 0 to 11 hold the per-line settings.
- Address 12 holds the two global enables.
- Address 13 is a command. Writing to it emits a one-cycle clear request for a chosen event flag.

Software uses this clear command so that a stale pending flag is cleared before the line that selects it is enabled.

Top module: `irq_event_router`

## Requirements
- R1: After reset, all selectors, line enables, the global enable and the non-maskable enable are zero. `irq_req`, `nmi_req` and `evt_clr_vld` are low, even while every event flag and `nmi_evt` are high.
- R2: A write to address k (0..11) programs output bit k, which is CPU line k+4. `cfg_wdata[6:0]` is the event number (0..127) and `cfg_wdata[7]` is the line enable. `irq_req[k]` is high in the cycle after a clock edge at which the line is enabled, the global enable is set and `evt_flag[event]` is high.
- R3: A line whose enable bit is zero never asserts, whatever its selected flag does.
- R4: Address 12 bit 0 is the global enable. While it is zero, every `irq_req` bit is low.
- R5: Address 12 bit 1 is the non-maskable enable. `nmi_req` follows `nmi_evt` with one cycle of delay while this enable is set, and it does not depend on the global enable.
- R6: A write to address 13 raises `evt_clr_vld` for exactly the following cycle, with `evt_clr_id` equal to `cfg_wdata[6:0]`. The write changes no selector and no enable.
- R7: A write to one line's address leaves every other line's selector and enable unchanged, so no other request line glitches.
- R8: Writes to addresses 14 and 15 have no effect on any line or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_flag | input | 128 | Latched event flags, index = event number |
| nmi_evt | input | 1 | Non-maskable event source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| irq_req | output | 12 | Maskable requests, bit k = CPU line k+4 |
| nmi_req | output | 1 | Non-maskable request |
| evt_clr_vld | output | 1 | One-cycle event-clear request |
| evt_clr_id | output | 7 | Event number to clear |

## Verification
The hardest case to reach from the ports is a reprogramming of one line's selector while a neighbouring line is continuously asserted. A glitch would appear only as a single-cycle drop on the neighbour. To provoke it, the stimulus holds line 0 active on event 63 and then rewrites line 1's selector across a sweep of event numbers, one of which matches the active flag. The neighbour is sampled in every cycle, and line 1 is expected to rise only on the matching value.

// File: rtl/irq_router_pkg.sv
// Package: shared sizing constants for the event-to-interrupt selector.
// Assumes: event space is a power of two; lines are numbered from FIRST_LINE on the CPU side.
package irq_router_pkg;
    localparam int N_EVT_DEF  = 128;
    localparam int N_LINE_DEF = 12;
    localparam int FIRST_LINE = 4;
endpackage

// File: rtl/irq_cfg_regs.sv
// Module: write-only configuration store. Holds per-line selector/enable,
// the global and non-maskable enables, and issues one-cycle clear commands.
// Assumes: CFG_W == SEL_W + 1 (enable bit sits just above the selector field).
module irq_cfg_regs #(
    parameter int N_LINE = 12,
    parameter int SEL_W  = 7,
    parameter int ADDR_W = 4,
    parameter int CFG_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [CFG_W-1:0]             wdata,
    output logic [N_LINE-1:0]            line_en,
    output logic [N_LINE-1:0][SEL_W-1:0] line_sel,
    output logic                         gie,
    output logic                         nmi_en,
    output logic                         clr_vld,
    output logic [SEL_W-1:0]             clr_id
);
    localparam int ADDR_CTL = N_LINE;
    localparam int ADDR_CLR = N_LINE + 1;
    localparam int EN_BIT   = SEL_W;

    logic hit_ctl;
    logic hit_clr;

    // Decode the two shared register addresses.
    always_comb begin
        hit_ctl = we && (addr == ADDR_W'(ADDR_CTL));
        hit_clr = we && (addr == ADDR_W'(ADDR_CLR));
    end

    for (genvar k = 0; k < N_LINE; k++) begin : g_line
        // Load one line's enable and selector only when its own address is hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_en[k]  <= 1'b0;
                line_sel[k] <= '0;
            end else if (we && (addr == ADDR_W'(k))) begin
                line_en[k]  <= wdata[EN_BIT];
                line_sel[k] <= wdata[SEL_W-1:0];
            end
        end
    end

    // Global and non-maskable enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie    <= 1'b0;
            nmi_en <= 1'b0;
        end else if (hit_ctl) begin
            gie    <= wdata[0];
            nmi_en <= wdata[1];
        end
    end

    // One-cycle clear command carrying the event number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_vld <= 1'b0;
            clr_id  <= '0;
        end else begin
            clr_vld <= hit_clr;
            clr_id  <= hit_clr ? wdata[SEL_W-1:0] : '0;
        end
    end
endmodule

// File: rtl/irq_line_gate.sv
// Module: one request line. Picks its selected flag and gates it with the
// line enable and global enable, then registers the result.
// Assumes: sel always indexes inside the flag vector (N_EVT == 2**SEL_W).
module irq_line_gate #(
    parameter int N_EVT = 128,
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_flag,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    input  logic             gie,
    output logic             req
);
    logic picked;

    // Select the flag this line watches.
    always_comb picked = evt_flag[sel];

    // Register the gated request so a selector change cannot glitch the output.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= picked && en && gie;
    end
endmodule

// File: rtl/irq_event_router.sv
// Module: top of the event-to-CPU interrupt selector. Output bit k drives CPU
// line k+FIRST_LINE. Assumes flags are already latched upstream and cleared
// there on evt_clr_vld.
module irq_event_router
    import irq_router_pkg::*;
#(
    parameter int N_EVT  = N_EVT_DEF,
    parameter int N_LINE = N_LINE_DEF,
    localparam int SEL_W  = $clog2(N_EVT),
    localparam int ADDR_W = $clog2(N_LINE + 2),
    localparam int CFG_W  = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_flag,
    input  logic              nmi_evt,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [N_LINE-1:0] irq_req,
    output logic              nmi_req,
    output logic              evt_clr_vld,
    output logic [SEL_W-1:0]  evt_clr_id
);
    logic [N_LINE-1:0]            line_en;
    logic [N_LINE-1:0][SEL_W-1:0] line_sel;
    logic                         gie;
    logic                         nmi_en;

    irq_cfg_regs #(
        .N_LINE (N_LINE),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W),
        .CFG_W  (CFG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .line_en  (line_en),
        .line_sel (line_sel),
        .gie      (gie),
        .nmi_en   (nmi_en),
        .clr_vld  (evt_clr_vld),
        .clr_id   (evt_clr_id)
    );

    for (genvar k = 0; k < N_LINE; k++) begin : g_gate
        irq_line_gate #(
            .N_EVT (N_EVT),
            .SEL_W (SEL_W)
        ) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_flag (evt_flag),
            .sel      (line_sel[k]),
            .en       (line_en[k]),
            .gie      (gie),
            .req      (irq_req[k])
        );
    end

    // Non-maskable path: gated only by its own enable, never by gie.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= nmi_evt && nmi_en;
    end
endmodule

// File: rtl/irq_router_chk.sv
// Module: property checker bound to irq_event_router.
// Assumes: reset held low across the first clock edges.
module irq_router_chk #(
    parameter int N_EVT  = 128,
    parameter int N_LINE = 12,
    parameter int SEL_W  = 7,
    parameter int ADDR_W = 4,
    parameter int CFG_W  = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_EVT-1:0]             evt_flag,
    input logic                         nmi_evt,
    input logic                         cfg_we,
    input logic [ADDR_W-1:0]            cfg_addr,
    input logic [CFG_W-1:0]             cfg_wdata,
    input logic [N_LINE-1:0]            irq_req,
    input logic                         nmi_req,
    input logic                         evt_clr_vld,
    input logic [SEL_W-1:0]             evt_clr_id,
    input logic [N_LINE-1:0]            line_en,
    input logic [N_LINE-1:0][SEL_W-1:0] line_sel,
    input logic                         gie,
    input logic                         nmi_en
);
    localparam int ADDR_CLR = N_LINE + 1;

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_req == '0 && !nmi_req && !evt_clr_vld)); // R1

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |-> $past(gie)); // R4

    AST_NMI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> $past(nmi_evt && nmi_en)); // R5

    AST_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr_vld |-> $past(cfg_we && cfg_addr == ADDR_W'(ADDR_CLR))); // R6

    AST_CLR_ID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && cfg_addr == ADDR_W'(ADDR_CLR)) |->
            (evt_clr_vld && evt_clr_id == $past(cfg_wdata[SEL_W-1:0]))); // R6

    AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && cfg_addr > ADDR_W'(ADDR_CLR)) |->
            ($stable(line_en) && $stable(line_sel) && $stable(gie) && $stable(nmi_en))); // R8

    for (genvar i = 0; i < N_LINE; i++) begin : g_line
        AST_REQ_NEEDS_EN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |-> $past(line_en[i] && evt_flag[line_sel[i]])); // R3

        AST_OTHER_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg_we && cfg_addr < ADDR_W'(N_LINE) && cfg_addr != ADDR_W'(i)) |->
                ($stable(line_sel[i]) && $stable(line_en[i]))); // R7
    end
endmodule

bind irq_event_router irq_router_chk #(
    .N_EVT  (N_EVT),
    .N_LINE (N_LINE),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W),
    .CFG_W  (CFG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_flag    (evt_flag),
    .nmi_evt     (nmi_evt),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .irq_req     (irq_req),
    .nmi_req     (nmi_req),
    .evt_clr_vld (evt_clr_vld),
    .evt_clr_id  (evt_clr_id),
    .line_en     (line_en),
    .line_sel    (line_sel),
    .gie         (gie),
    .nmi_en      (nmi_en)
);

// File: tb/sim_irq_event_router.sv
// Bench: table-driven routing checks, then directed reset and corner cases.
module sim_irq_event_router;
    localparam int N_EVT  = 128;
    localparam int N_LINE = 12;
    localparam int SEL_W  = 7;
    localparam int ADDR_W = 4;
    localparam int CFG_W  = 8;
    localparam int N_VEC  = 8;
    // {line index[3:0], event number[6:0]}
    localparam logic [10:0] VEC [N_VEC] = '{
        {4'd0, 7'd63}, {4'd1, 7'd10}, {4'd11, 7'd127}, {4'd5, 7'd0},
        {4'd6, 7'd3},  {4'd2, 7'd4},  {4'd9, 7'd64},   {4'd10, 7'd31}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_EVT-1:0]  evt_flag = '1;
    logic              nmi_evt = 1'b1;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [N_LINE-1:0] irq_req;
    logic              nmi_req;
    logic              evt_clr_vld;
    logic [SEL_W-1:0]  evt_clr_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_event_router u0 (
        .clk(clk), .rst_n(rst_n), .evt_flag(evt_flag), .nmi_evt(nmi_evt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .irq_req(irq_req), .nmi_req(nmi_req),
        .evt_clr_vld(evt_clr_vld), .evt_clr_id(evt_clr_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the write done.
    task automatic wr(input int a, input int d);
        cfg_we = 1'b1;
        cfg_addr = ADDR_W'(a);
        cfg_wdata = CFG_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", 32'(irq_req), 0);
        chk("R1 nmi after reset", 32'(nmi_req), 0);
        chk("R1 clr after reset", 32'(evt_clr_vld), 0);
        wr(12, 1);                       // global enable only
        @(negedge clk);
        chk("R1 enables zero, all flags high", 32'(irq_req), 0);
        chk("R5 nmi gated by its enable", 32'(nmi_req), 0);
        wr(12, 3);
        @(negedge clk);
        chk("R5 nmi follows source", 32'(nmi_req), 1);

        // R2: table of line/event pairs
        for (int v = 0; v < N_VEC; v++) begin
            int ln = int'(VEC[v][10:7]);
            int ev = int'(VEC[v][6:0]);
            evt_flag = '0;
            evt_flag[ev] = 1'b1;
            wr(ln, 128 + ev);
            @(negedge clk);
            chk("R2 routed flag raises line", 32'(irq_req), 32'(1) << ln);
            evt_flag = '1;
            evt_flag[ev] = 1'b0;
            @(negedge clk);
            chk("R2 other flags do not raise line", 32'(irq_req), 0);
            wr(ln, 0);
        end

        // R3: enable bit gates a line
        evt_flag = '0;
        evt_flag[63] = 1'b1;
        wr(0, 63);
        @(negedge clk);
        chk("R3 disabled line stays low", 32'(irq_req), 0);
        wr(0, 128 + 63);
        @(negedge clk);
        chk("R3 enabled line rises", 32'(irq_req), 1);

        // R4 / R5: global enable off, nmi unaffected
        wr(12, 2);
        @(negedge clk);
        chk("R4 global enable off", 32'(irq_req), 0);
        chk("R5 nmi independent of global enable", 32'(nmi_req), 1);
        wr(12, 1);
        @(negedge clk);
        chk("R5 nmi enable off", 32'(nmi_req), 0);
        chk("R4 global enable back on", 32'(irq_req), 1);

        // R7: sweep line 1 selector while line 0 is held high
        for (int e = 60; e < 67; e++) begin
            wr(1, 128 + e);
            chk("R7 neighbour steady during write", 32'(irq_req[0]), 1);
            @(negedge clk);
            chk("R7 neighbour steady after write", 32'(irq_req[0]), 1);
            chk("R7 written line follows its selector", 32'(irq_req[1]), (e == 63) ? 1 : 0);
        end
        wr(1, 0);

        // R6: clear command
        cfg_we = 1'b1;
        cfg_addr = ADDR_W'(13);
        cfg_wdata = CFG_W'(8'h55);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R6 clear strobe", 32'(evt_clr_vld), 1);
        chk("R6 clear id", 32'(evt_clr_id), 32'h55);
        @(negedge clk);
        chk("R6 clear strobe single cycle", 32'(evt_clr_vld), 0);
        chk("R6 config untouched by clear", 32'(irq_req), 1);

        // R8: high addresses ignored
        evt_flag = '1;
        wr(14, 128);
        wr(15, 0);
        @(negedge clk);
        chk("R8 writes to 14/15 ignored", 32'(irq_req), 1);
        chk("R8 clear not issued by 14/15", 32'(evt_clr_vld), 0);

        // R1: reset mid-run returns to quiet state
        rst_n = 1'b0;
        nmi_evt = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after second reset", 32'(irq_req), 0);
        wr(12, 3);
        @(negedge clk);
        chk("R1 line config cleared by reset", 32'(irq_req), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule